// File: doc/BRIEF.md
# MII Management Command Engine

This block runs single clause-22 management transactions toward an Ethernet PHY. Software programs the engine through a small register port: a configuration register sets the management clock divisor and whether the preamble is sent. For a write it loads the 16-bit data register and then writes a command word. The engine raises a busy flag and shifts the whole frame out on MDIO, clocked by a divided MDC. On a read it captures the PHY's 16 returned bits into the same data register. Software polls busy and, after a read, fetches the result.

MDIO is split into `mdio_o`, `mdio_oe` and `mdio_i`, so the pad tri-state (or a bench PHY model) sits outside the block. A self-clearing soft reset bit in the configuration register aborts any transaction in flight and returns the engine to its defaults. No data stream crosses the block, so every pin is a plain control or status pin and there is no valid/ready handshake. A register write takes effect at the clock edge where `wr_en` is high. `rd_data` follows `rd_addr` combinationally.

Register addresses: 0 command, 1 data, 2 status, 3 configuration.

Top module: `mii_mgmt_engine`

## Requirements
- R1: A command word is accepted only when it is written while the engine is idle and not in soft reset, and only when exactly one of bit 15 (read) or bit 14 (write) is set. Bits 9:5 give the PHY address and bits 4:0 the register number. Status bit 0 reads 1 from the cycle after acceptance.
- R2: A write frame is sent with `mdio_oe` high throughout, most significant bit first, in this order: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the 16 data bits.
- R3: A read frame uses opcode 10. `mdio_oe` is low for the two turnaround bits and the 16 data bits. Each data bit is sampled from `mdio_i` at the rising MDC edge, and the assembled word is readable at the data register once busy clears.
- R4: MDC is low while idle. During a transaction it is low for H cycles and then high for H cycles, where H = floor((div_m1+1)/2), or 1 if that is 0, and div_m1 is configuration bits 16:9. MDIO outputs change only at a falling MDC edge or at the start of a transaction.
- R5: Busy reads 1 for exactly 2·H·N cycles after the acceptance edge, where N is 64 bits, or 32 when the preamble is suppressed.
- R6: Configuration bit 8 set suppresses the 32-bit preamble, so the frame starts with the start bits.
- R7: A command written while busy, or one with both or neither of bits 15:14 set, is ignored. The transaction in flight is undisturbed and no new one starts.
- R8: Writes to the data register, and writes to the divisor and suppress fields, are ignored while busy.
- R9: Writing 1 to configuration bit 0 aborts any transaction: busy clears and `mdio_oe` is released on the next cycle. Bit 0 then reads 1 for RST_CYCLES cycles. Afterwards the data register is 0 and the configuration holds div_m1 = DEF_DIV_M1 with suppression off.
- R10: After `rst_n` the status reads 0, data reads 0, configuration reads DEF_DIV_M1 in bits 16:9, MDC is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write value |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read value (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit index or opcode shows up at once as a wrong level on `mdio_o` at the very MDC rising edge where a PHY would sample it. A divider or counter error shows as a busy window that differs from 2·H·N cycles, and it is visible the moment busy drops. A lost turnaround release or a misaligned sample shows as `mdio_oe` high in the read data window, or as a shifted value in the data register right after the transaction ends. An ignored-command fault shows as busy staying high, or as extra MDC edges beyond the expected frame length.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CFG  = 2'd3;

  localparam int CMD_RD_BIT  = 15;
  localparam int CMD_WR_BIT  = 14;
  localparam int CFG_RST_BIT = 0;
  localparam int CFG_SUP_BIT = 8;
  localparam int CFG_DIV_LSB = 9;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] regad;
  } mgmt_cmd_t;
endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W:0]   sum;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  always_comb begin
    sum  = {1'b0, div_m1} + 1'b1;
    half = sum[DIV_W:1];
    if (half == '0) half = {{(DIV_W-1){1'b0}}, 1'b1};
  end

  assign at_end  = run && (cnt == half - 1'b1);
  assign rise_ev = at_end && !mdc;
  assign fall_ev = at_end && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mii_frame_ctl.sv
module mii_frame_ctl
  import mii_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  input  logic        sup,
  input  mgmt_cmd_t   cmd,
  input  logic [15:0] wdata,
  input  logic        rise_ev,
  input  logic        fall_ev,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        load_rd,
  output logic [15:0] rdata
);
  logic [FRAME_BITS-1:0] frame;
  logic [IDX_W-1:0]      idx;
  logic                  is_rd;
  logic                  last;

  assign last    = (idx == IDX_W'(FRAME_BITS - 1));
  assign done    = busy && fall_ev && last;
  assign load_rd = done && is_rd;
  assign mdio_o  = busy && frame[IDX_W'(FRAME_BITS - 1) - idx];
  assign mdio_oe = busy && (!is_rd || idx < IDX_W'(TA_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      is_rd <= 1'b0;
      frame <= '0;
      rdata <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      is_rd <= cmd.rd;
      idx   <= sup ? IDX_W'(PRE_BITS) : '0;
      frame <= {{PRE_BITS{1'b1}}, 2'b01, cmd.rd ? 2'b10 : 2'b01, cmd.phy, cmd.regad,
                cmd.rd ? 2'b00 : 2'b10, cmd.rd ? 16'h0000 : wdata};
    end else if (busy) begin
      if (rise_ev && is_rd && idx >= IDX_W'(DATA_IDX))
        rdata <= {rdata[14:0], mdio_i};
      if (fall_ev) begin
        if (last) busy <= 1'b0;
        else      idx  <= idx + 1'b1;
      end
    end
  end

  // R4
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_ev && !abort) |=> ($stable(mdio_o) && $stable(mdio_oe)));
  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !mdio_oe));
endmodule

// File: rtl/mii_mgmt_engine.sv
module mii_mgmt_engine
  import mii_mgmt_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int DEF_DIV_M1 = 39,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int RST_W = $clog2(RST_CYCLES + 1);
  localparam logic [DIV_W-1:0] DIV_DEF = DIV_W'(DEF_DIV_M1);

  logic [DIV_W-1:0] div_q;
  logic             sup_q;
  logic [15:0]      data_q;
  logic [RST_W-1:0] rst_cnt;
  mgmt_cmd_t        cmd_q, cmd_in;
  logic             in_rst, busy, done, load_rd, rise_ev, fall_ev;
  logic             cmd_hit, abort, cfg_wr, data_wr;
  logic [15:0]      rdata;

  assign in_rst  = (rst_cnt != '0);
  assign cmd_in  = '{rd: wr_data[CMD_RD_BIT], phy: wr_data[9:5], regad: wr_data[4:0]};
  assign cmd_hit = wr_en && wr_addr == ADDR_CMD && !busy && !in_rst &&
                   (wr_data[CMD_RD_BIT] ^ wr_data[CMD_WR_BIT]);
  assign abort   = wr_en && wr_addr == ADDR_CFG && wr_data[CFG_RST_BIT] && !in_rst;
  assign cfg_wr  = wr_en && wr_addr == ADDR_CFG && !wr_data[CFG_RST_BIT] && !busy && !in_rst;
  assign data_wr = wr_en && wr_addr == ADDR_DATA && !busy && !in_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DIV_DEF;
      sup_q   <= 1'b0;
      data_q  <= '0;
      rst_cnt <= '0;
      cmd_q   <= '0;
    end else begin
      if (in_rst) rst_cnt <= rst_cnt - 1'b1;
      if (abort) begin
        rst_cnt <= RST_W'(RST_CYCLES);
        div_q   <= DIV_DEF;
        sup_q   <= 1'b0;
        data_q  <= '0;
      end else begin
        if (cfg_wr) begin
          div_q <= wr_data[CFG_DIV_LSB +: DIV_W];
          sup_q <= wr_data[CFG_SUP_BIT];
        end
        if (data_wr) data_q <= wr_data[15:0];
        else if (load_rd) data_q <= rdata;
        if (cmd_hit) cmd_q <= cmd_in;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CMD:  rd_data = {16'h0, cmd_q.rd, ~cmd_q.rd, 4'h0, cmd_q.phy, cmd_q.regad};
      ADDR_DATA: rd_data = {16'h0, data_q};
      ADDR_STAT: rd_data = {31'h0, busy};
      default: begin
        rd_data[CFG_DIV_LSB +: DIV_W] = div_q;
        rd_data[CFG_SUP_BIT]          = sup_q;
        rd_data[CFG_RST_BIT]          = in_rst;
      end
    endcase
  end

  mii_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_m1(div_q),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev));

  mii_frame_ctl u_frame (
    .clk(clk), .rst_n(rst_n), .start(cmd_hit), .abort(abort), .sup(sup_q),
    .cmd(cmd_in), .wdata(data_q), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .load_rd(load_rd), .rdata(rdata));

  // R1
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wr_addr == ADDR_CMD &&
                          (wr_data[CMD_RD_BIT] ^ wr_data[CMD_WR_BIT])));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !abort) |=> busy);
  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !abort) |=> $stable(data_q));
  // R9
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |-> (!busy && !mdio_oe));
endmodule

// File: tb/test_mii_mgmt_engine.sv
`timescale 1ns/1ps
module test_mii_mgmt_engine;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic mdc, mdio_o, mdio_oe;
  int total = 0, bad = 0, col_n = 0;
  logic col_o [64];
  logic col_oe [64];
  logic phy_arm = 1'b0;
  logic [15:0] phy_val = '0;

  always #4 clk = ~clk;

  mii_mgmt_engine i_mii_mgmt_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // rd(1) sup(1) div_m1(8) phy(5) reg(5) value(16)
  localparam logic [35:0] VEC [4] = '{
    {1'b0, 1'b0, 8'd3, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 1'b0, 8'd3, 5'h1F, 5'h01, 16'h796D},
    {1'b0, 1'b1, 8'd0, 5'h12, 5'h1E, 16'h0001},
    {1'b1, 1'b1, 8'd6, 5'h00, 5'h11, 16'h8000}};

  always @(posedge mdc) begin
    if (col_n < 64) begin
      col_o[col_n] = mdio_o;
      col_oe[col_n] = mdio_oe;
      col_n = col_n + 1;
    end
  end

  always begin
    @(negedge mdio_oe);
    #1;
    if (phy_arm) begin
      @(negedge mdc); mdio_i = 1'b0;
      for (int j = 15; j >= 0; j--) begin
        @(negedge mdc); mdio_i = phy_val[j];
      end
      phy_arm = 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic int half_of(input logic [7:0] dm1);
    int h = (int'(dm1) + 1) / 2;
    return (h == 0) ? 1 : h;
  endfunction

  task automatic wait_idle(output int cyc);
    logic [31:0] s;
    cyc = 0;
    bus_rd(2'd2, s);
    while (s[0] && cyc < 10000) begin
      cyc++;
      @(negedge clk);
      bus_rd(2'd2, s);
    end
  endtask

  task automatic check_frame(input logic rd, input logic sup, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] v, input string tag);
    logic [63:0] f;
    int s, n, errs;
    f = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b00 : 2'b10, rd ? 16'h0 : v};
    s = sup ? 32 : 0;
    n = 64 - s;
    errs = 0;
    for (int j = 0; j < n; j++) begin
      logic eoe = !rd || (s + j) < 46;
      if (col_oe[j] !== eoe) errs++;
      else if (eoe && col_o[j] !== f[63 - (s + j)]) errs++;
    end
    chk(errs == 0 && col_n == n, tag, 32'(col_n), 32'(n));
  endtask

  initial begin
    int cyc;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    bus_rd(2'd2, r); chk(r == 0, "R10 status", r, 0);
    bus_rd(2'd1, r); chk(r == 0, "R10 data", r, 0);
    bus_rd(2'd3, r); chk(r == 32'h4E00, "R10 cfg", r, 32'h4E00);
    chk(!mdc && !mdio_oe, "R10 mdc/oe", {mdc, mdio_oe}, 0);

    for (int k = 0; k < 4; k++) begin
      logic rd, sup; logic [7:0] dm1; logic [4:0] phy, rg; logic [15:0] v;
      {rd, sup, dm1, phy, rg, v} = VEC[k];
      @(negedge clk);
      bus_wr(2'd3, {15'h0, dm1, sup, 8'h0});
      if (!rd) bus_wr(2'd1, {16'h0, v});
      phy_val = v; phy_arm = rd; col_n = 0;
      bus_wr(2'd0, {16'h0, rd, !rd, 4'h0, phy, rg});
      bus_rd(2'd2, r); chk(r[0] == 1'b1, "R1 busy set", r, 1);
      wait_idle(cyc);
      chk(cyc == 2 * half_of(dm1) * (sup ? 32 : 64), "R5 R4 R6 busy length", cyc,
          2 * half_of(dm1) * (sup ? 32 : 64));
      check_frame(rd, sup, phy, rg, v, rd ? "R3 read frame" : "R2 write frame");
      bus_rd(2'd1, r); chk(r[15:0] == v, rd ? "R3 read data" : "R2 data kept", r, v);
      chk(!mdc, "R4 mdc idle low", mdc, 0);
      mdio_i = 1'b1;
    end

    // R7 invalid commands: both bits, neither bit
    bus_wr(2'd0, 32'h0000_C021);
    bus_rd(2'd2, r); chk(r == 0, "R7 both bits ignored", r, 0);
    bus_wr(2'd0, 32'h0000_0021);
    repeat (3) @(negedge clk);
    bus_rd(2'd2, r); chk(r == 0 && !mdio_oe, "R7 no bits ignored", r, 0);

    // R7 R8 writes while busy
    bus_wr(2'd3, 32'h0000_0600);
    bus_wr(2'd1, 32'h0000_1234);
    col_n = 0;
    bus_wr(2'd0, 32'h0000_4000 | (5'h03 << 5) | 5'h04);
    repeat (10) @(negedge clk);
    bus_wr(2'd0, 32'h0000_8000 | (5'h07 << 5) | 5'h02);
    bus_wr(2'd1, 32'h0000_FFFF);
    bus_wr(2'd3, 32'h0000_0000);
    wait_idle(cyc);
    check_frame(1'b0, 1'b0, 5'h03, 5'h04, 16'h1234, "R7 frame undisturbed");
    repeat (20) @(negedge clk);
    bus_rd(2'd2, r); chk(r == 0 && col_n == 64, "R7 no second frame", 32'(col_n), 64);
    bus_rd(2'd1, r); chk(r == 32'h1234, "R8 data write ignored", r, 32'h1234);
    bus_rd(2'd3, r); chk(r == 32'h0600, "R8 cfg write ignored", r, 32'h0600);

    // R9 soft reset during a transaction
    bus_wr(2'd0, 32'h0000_4000 | (5'h05 << 5) | 5'h06);
    repeat (30) @(negedge clk);
    bus_wr(2'd3, 32'h0000_0001);
    bus_rd(2'd2, r); chk(r == 0 && !mdio_oe, "R9 abort", {r[0], mdio_oe}, 0);
    begin
      int hi = 0;
      for (int j = 0; j < 8; j++) begin
        bus_rd(2'd3, r);
        if (r[0]) hi++;
        @(negedge clk);
      end
      chk(hi == 4, "R9 reset bit length", hi, 4);
    end
    bus_rd(2'd3, r); chk(r == 32'h4E00, "R9 cfg default", r, 32'h4E00);
    bus_rd(2'd1, r); chk(r == 0, "R9 data cleared", r, 0);
    chk(!mdc, "R9 mdc low", mdc, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule